// File: doc/BRIEF.md
# Cell Sense-Line Break Filter

This block decides whether a cell sense line of a series battery stack has come loose. An analog front end compares each cell's measured voltage with a low open-wire threshold. It presents one flag per cell position, and the flag is high when that cell reads at or below the threshold. Once per detection cycle a sample strobe arrives. The filter then turns the noisy per-sample verdicts into one registered fault flag.

Entry and exit follow the same rule. The flag changes only after a programmable number of consecutive samples that all point the other way. A single sample that points back toward the current state restarts the run. The run length is programmable in whole detection cycles. A quick test input shortens it to one sample in both directions, so that board-level tests finish fast. Only the configured number of cells (three to five) take part. Dropping the enable clears the filter.

Top module: `wire_break_filter`

## Requirements
- R1: While reset is held, and on the first cycle after it, `fault` is 0.
- R2: When `fault` is 0, it rises on the clock edge that takes the D-th consecutive strobed sample in which at least one active cell flag is 1. D is the effective delay.
- R3: When `fault` is 0, a strobed sample in which every active flag is 0 restarts the detection run. Another full D low samples are then needed.
- R4: When `fault` is 1, it falls on the edge that takes the D-th consecutive strobed sample in which every active flag is 0.
- R5: When `fault` is 1, a strobed sample with any active flag set to 1 restarts the release run. Another full D clear samples are then needed.
- R6: D equals `delay_cycles` for values 1 to 14. A value of 0 acts as 1, and 15 acts as 14.
- R7: While `quick_mode` is 1, D is 1 in both directions, whatever `delay_cycles` holds.
- R8: Bit i of `cell_low` (bit 0 is the lowest cell) is active only when i < N, where N is `cell_count`. N below 3 acts as 3 and N above 5 acts as 5. Inactive bits have no effect on `fault`.
- R9: While `enable` is 0, `fault` goes to 0 on the next edge, the run is cleared, and strobes are ignored. This holds even when a strobe falls in the same cycle.
- R10: In a cycle without `sample_stb`, `fault` and the run are unchanged, whatever the cell flags do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | 1 = filter runs, 0 = cleared and idle |
| sample_stb | input | 1 | One-cycle pulse, once per detection cycle |
| quick_mode | input | 1 | 1 = one-sample delay in both directions |
| cell_count | input | 3 | Number of series cells (3 to 5, clamped) |
| delay_cycles | input | 4 | Consecutive samples needed to change state (1 to 14, clamped) |
| cell_low | input | 5 | Per-cell flag, 1 = at or below the open-wire threshold |
| fault | output | 1 | Registered open-wire fault flag |

## Verification
The filter's clear path and its counting path can both act in one cycle. This happens when `enable` drops in the very cycle that carries the strobe which would complete a detection run. The bench builds a run one sample short of D. It then delivers the final low sample with `enable` already at 0. `fault` must stay 0, and after `enable` returns a fresh full run must be needed. A second collision is a run-completing strobe that arrives together with a change of `cell_count`. The mask in force in that same cycle must decide the outcome.

// File: rtl/wire_break_filter.sv
module wire_break_filter #(
  parameter int MAX_CELLS = 5,
  parameter int MIN_CELLS = 3,
  parameter int MAX_DELAY = 14,
  parameter int CNT_W     = 4,
  localparam int CC_W     = $clog2(MAX_CELLS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 sample_stb,
  input  logic                 quick_mode,
  input  logic [CC_W-1:0]      cell_count,
  input  logic [CNT_W-1:0]     delay_cycles,
  input  logic [MAX_CELLS-1:0] cell_low,
  output logic                 fault
);

  logic [CC_W-1:0]      eff_cells;
  logic [MAX_CELLS-1:0] cell_mask;
  logic [CNT_W-1:0]     eff_delay;
  logic [CNT_W-1:0]     run_cnt;
  logic [CNT_W:0]       run_inc;
  logic                 any_low;
  logic                 toward;

  assign eff_cells = (cell_count < CC_W'(MIN_CELLS)) ? CC_W'(MIN_CELLS) :
                     (cell_count > CC_W'(MAX_CELLS)) ? CC_W'(MAX_CELLS) : cell_count;

  for (genvar g = 0; g < MAX_CELLS; g++) begin : g_mask
    assign cell_mask[g] = (CC_W'(g) < eff_cells);
  end

  assign any_low   = |(cell_low & cell_mask);
  assign eff_delay = quick_mode                        ? CNT_W'(1) :
                     (delay_cycles == '0)              ? CNT_W'(1) :
                     (delay_cycles > CNT_W'(MAX_DELAY)) ? CNT_W'(MAX_DELAY) : delay_cycles;

  // a sample "toward" the opposite state extends the run; anything else restarts it
  assign toward  = fault ? !any_low : any_low;
  assign run_inc = {1'b0, run_cnt} + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      fault   <= 1'b0;
      run_cnt <= '0;
    end else if (sample_stb) begin
      if (!toward) begin
        run_cnt <= '0;
      end else if (run_inc >= {1'b0, eff_delay}) begin
        fault   <= !fault;
        run_cnt <= '0;
      end else begin
        run_cnt <= run_inc[CNT_W-1:0];
      end
    end
  end

endmodule

// File: rtl/wire_break_filter_chk.sv
module wire_break_filter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       sample_stb,
  input logic       quick_mode,
  input logic [4:0] cell_low,
  input logic       fault
);

  // R9: disable forces the flag low
  a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !fault);

  // R10: no strobe, no change
  a_r10_hold_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !sample_stb) |=> $stable(fault));

  // R2: the flag only rises on an enabled strobe
  a_r2_rise_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> $past(sample_stb && enable));

  // R3: a clear sample never raises the flag
  a_r3_clear_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && sample_stb && cell_low == 5'b0 && !fault) |=> !fault);

  // R5: a low sample on an always-active cell never releases the flag
  a_r5_low_keeps_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && sample_stb && cell_low[2:0] != 3'b0 && fault) |=> fault);

  // R7: quick mode enters in one sample
  a_r7_quick_enter: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && quick_mode && sample_stb && cell_low[2:0] != 3'b0 && !fault) |=> fault);

  // R7: quick mode releases in one sample
  a_r7_quick_release: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && quick_mode && sample_stb && cell_low == 5'b0 && fault) |=> !fault);

endmodule

bind wire_break_filter wire_break_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .sample_stb(sample_stb),
  .quick_mode(quick_mode), .cell_low(cell_low), .fault(fault)
);

// File: tb/test_wire_break_filter.sv
module test_wire_break_filter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       sample_stb = 1'b0;
  logic       quick_mode = 1'b0;
  logic [2:0] cell_count = 3'd5;
  logic [3:0] delay_cycles = 4'd9;
  logic [4:0] cell_low = 5'b0;
  logic       fault;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wire_break_filter i_wire_break_filter (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sample_stb(sample_stb),
    .quick_mode(quick_mode), .cell_count(cell_count), .delay_cycles(delay_cycles),
    .cell_low(cell_low), .fault(fault)
  );

  task automatic check(input string req, input logic exp);
    checks++;
    if (fault !== exp) begin
      failures++;
      $display("FAIL %s: fault=%b expected=%b", req, fault, exp);
    end
  endtask

  task automatic pulse(input logic [4:0] v);
    @(negedge clk);
    cell_low = v;
    sample_stb = 1'b1;
    @(negedge clk);
    sample_stb = 1'b0;
  endtask

  task automatic run(input int n, input logic [4:0] v);
    for (int i = 0; i < n; i++) pulse(v);
  endtask

  task automatic clean();
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    enable = 1'b1;
    quick_mode = 1'b0;
    cell_count = 3'd5;
    delay_cycles = 4'd9;
    cell_low = 5'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 during reset", 1'b0);
    rst_n = 1'b1;
    enable = 1'b1;
    @(negedge clk);
    check("R1 after reset", 1'b0);
  endtask

  task automatic t_detect_release();
    clean();
    run(8, 5'b00001);
    check("R2 eight low samples", 1'b0);
    pulse(5'b00001);
    check("R2 ninth low sample", 1'b1);
    run(8, 5'b00000);
    check("R4 eight clear samples", 1'b1);
    pulse(5'b00000);
    check("R4 ninth clear sample", 1'b0);
  endtask

  task automatic t_restart();
    clean();
    run(8, 5'b00100);
    pulse(5'b00000);
    run(8, 5'b00010);
    check("R3 run restarted by clear sample", 1'b0);
    pulse(5'b00010);
    check("R3 full run after restart", 1'b1);
    run(8, 5'b00000);
    pulse(5'b00001);
    run(8, 5'b00000);
    check("R5 release run restarted", 1'b1);
    pulse(5'b00000);
    check("R5 full release after restart", 1'b0);
  endtask

  task automatic t_delay();
    clean();
    delay_cycles = 4'd1;
    pulse(5'b00001);
    check("R6 delay 1 enter", 1'b1);
    pulse(5'b00000);
    check("R6 delay 1 release", 1'b0);
    delay_cycles = 4'd0;
    pulse(5'b00001);
    check("R6 delay 0 acts as 1", 1'b1);
    clean();
    delay_cycles = 4'd15;
    run(13, 5'b00001);
    check("R6 delay 15 after 13", 1'b0);
    pulse(5'b00001);
    check("R6 delay 15 acts as 14", 1'b1);
    delay_cycles = 4'd14;
    run(13, 5'b00000);
    check("R6 delay 14 release after 13", 1'b1);
    pulse(5'b00000);
    check("R6 delay 14 release", 1'b0);
  endtask

  task automatic t_quick();
    clean();
    quick_mode = 1'b1;
    pulse(5'b00100);
    check("R7 quick enter", 1'b1);
    pulse(5'b00000);
    check("R7 quick release", 1'b0);
  endtask

  task automatic t_mask();
    clean();
    cell_count = 3'd3;
    run(9, 5'b11000);
    check("R8 cells 4,5 masked at N=3", 1'b0);
    cell_count = 3'd4;
    run(9, 5'b10000);
    check("R8 cell 5 masked at N=4", 1'b0);
    run(9, 5'b01000);
    check("R8 cell 4 active at N=4", 1'b1);
    clean();
    cell_count = 3'd1;
    run(9, 5'b11000);
    check("R8 N=1 acts as 3", 1'b0);
    cell_count = 3'd7;
    run(9, 5'b10000);
    check("R8 N=7 acts as 5", 1'b1);
    clean();
    run(8, 5'b10000);
    @(negedge clk);
    cell_count = 3'd4;
    cell_low = 5'b10000;
    sample_stb = 1'b1;
    @(negedge clk);
    sample_stb = 1'b0;
    check("R8 mask changed with final strobe", 1'b0);
  endtask

  task automatic t_disable();
    clean();
    run(9, 5'b00001);
    check("R9 set before disable", 1'b1);
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check("R9 disable clears fault", 1'b0);
    run(9, 5'b00001);
    check("R9 strobes ignored while disabled", 1'b0);
    enable = 1'b1;
    run(8, 5'b00001);
    @(negedge clk);
    enable = 1'b0;
    cell_low = 5'b00001;
    sample_stb = 1'b1;
    @(negedge clk);
    sample_stb = 1'b0;
    enable = 1'b1;
    check("R9 disable wins over final strobe", 1'b0);
    run(8, 5'b00001);
    check("R9 run cleared by disable", 1'b0);
    pulse(5'b00001);
    check("R9 full run after re-enable", 1'b1);
  endtask

  task automatic t_hold();
    clean();
    run(8, 5'b00001);
    @(negedge clk);
    cell_low = 5'b00000;
    repeat (5) @(negedge clk);
    cell_low = 5'b11111;
    repeat (5) @(negedge clk);
    check("R10 no strobe keeps fault low", 1'b0);
    pulse(5'b00001);
    check("R10 run kept across idle cycles", 1'b1);
    @(negedge clk);
    cell_low = 5'b00000;
    repeat (6) @(negedge clk);
    check("R10 no strobe keeps fault high", 1'b1);
  endtask

  initial begin
    t_reset();
    t_detect_release();
    t_restart();
    t_delay();
    t_quick();
    t_mask();
    t_disable();
    t_hold();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule